// File: doc/BRIEF.md
# Synchronous SRAM Read Return Stage

This block sits between the storage array of a synchronous burst SRAM and its data pins. Each clock the command controller hands it a command (read, write or deselect) together with the word the array produced for that cycle. The block returns read words on a 32-bit data bus. It also produces a per-byte drive-enable vector that stands in for the tristate drivers: a byte is at high impedance whenever its enable is low, and its bus bits are then zero.

A static mode input selects one of two latencies. With the input low, the word captured at a clock edge reaches the bus directly after that edge, bypassing the output register (flow-through). With the input high, the word passes through one more rising-edge register and appears one clock later (pipelined). Deselect and write commands shut the drivers off in the cycle right after they are captured, one stage ahead of read data. As a result, a pipelined read word that is still in flight when a deselect or write arrives is never driven.

An asynchronous active-low output enable and a sleep input can both force the drivers off at any moment. While sleep is high, and for a parameterised number of recovery clocks after it falls, incoming commands are treated as deselects.

Top module: `sram_rdret`

## Requirements
- R1: While and directly after reset, dq_en_o is 4'b0000 and dq_o is zero.
- R2: Flow-through (pipe_mode_i=0): when a read (cmd_i=2'b01) is captured at a rising edge, dq_o equals that cycle's rd_data_i and dq_en_o=4'b1111 after that edge, unless oe_ni or sleep_i is high.
- R3: Pipelined (pipe_mode_i=1): a read captured at edge k is driven after edge k+1, and only if a read is also captured at edge k+1; nothing is driven after edge k alone.
- R4: Back-to-back reads return one new word per clock in both modes, in the order the reads were issued.
- R5: A deselect (cmd_i=2'b00 or 2'b11) captured at an edge makes dq_en_o zero after that edge in both modes, including when a pipelined read word is waiting in the output register.
- R6: A write (cmd_i=2'b10) captured at an edge makes dq_en_o zero after that edge, whatever the other inputs are.
- R7: oe_ni high forces dq_en_o to zero combinationally, without waiting for a clock edge; oe_ni low enables drivers only when valid read data is present.
- R8: dq_en_o is always either 4'b0000 or 4'b1111 (all bytes are driven on a read), and dq_o is zero whenever dq_en_o is zero.
- R9: While sleep_i is high, dq_en_o is zero and every captured command behaves as a deselect.
- R10: After sleep_i falls, commands captured at the first WAKE_CYCLES rising edges are ignored; the next edge accepts commands normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pipe_mode_i | input | 1 | 1 = pipelined output, 0 = flow-through |
| cmd_i | input | 2 | 00/11 deselect, 01 read, 10 write |
| rd_data_i | input | 32 | Array read word for this cycle |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Low-power request, active high |
| dq_o | output | 32 | Returned read data, zero when not driven |
| dq_en_o | output | 4 | Per-byte driver enable |

## Verification
Two functions can act in the same cycle. The first pair is a pipelined read word in the output register together with a deselect or write just captured: SCD cut-off must win, and the bench provokes this directly with a read that is followed straight away by a deselect, and again by a write. The second pair is a captured read together with an asynchronous gate (oe_ni or sleep_i) raised during the same cycle: the gate must win without waiting for an edge. Random phases with a fixed seed mix all commands with toggling gates in both modes, and compare every cycle against a bench model of the two stages derived from the requirements.

// File: rtl/sram_rdret_pkg.sv
package sram_rdret_pkg;
   typedef enum logic [1:0] {
      CMD_DESEL  = 2'b00,
      CMD_READ   = 2'b01,
      CMD_WRITE  = 2'b10,
      CMD_DESEL2 = 2'b11
   } cmd_e;
endpackage

// File: rtl/rdret_wake.sv
module rdret_wake #(
   parameter int WAKE_CYCLES = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sleep_i,
   output logic blocked_o
);
   localparam int CW = $clog2(WAKE_CYCLES + 1);
   localparam logic [CW-1:0] WAKE_LD = CW'(WAKE_CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (sleep_i)         cnt_q <= WAKE_LD;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign blocked_o = sleep_i || (cnt_q != '0);
endmodule

// File: rtl/rdret_stage.sv
module rdret_stage #(
   parameter int DW = 32,
   parameter int NB = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [NB-1:0] vld_i,
   input  logic [DW-1:0] data_i,
   output logic [NB-1:0] vld_o,
   output logic [DW-1:0] data_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_o  <= '0;
         data_o <= '0;
      end else begin
         vld_o  <= vld_i;
         data_o <= data_i;
      end
   end
endmodule

// File: rtl/rdret_lane.sv
module rdret_lane #(
   parameter int BW = 8
) (
   input  logic          pipe_i,
   input  logic          gate_i,
   input  logic          a_vld_i,
   input  logic [BW-1:0] a_data_i,
   input  logic          b_vld_i,
   input  logic [BW-1:0] b_data_i,
   output logic          en_o,
   output logic [BW-1:0] dq_o
);
   logic          vld;
   logic [BW-1:0] sel;

   always_comb begin
      // a pending pipelined word is dropped once stage A holds no read
      vld  = pipe_i ? (b_vld_i && a_vld_i) : a_vld_i;
      sel  = pipe_i ? b_data_i : a_data_i;
      en_o = vld && gate_i;
      dq_o = en_o ? sel : '0;
   end
endmodule

// File: rtl/sram_rdret.sv
module sram_rdret #(
   parameter int DATA_W      = 32,
   parameter int BYTE_W      = 8,
   parameter int WAKE_CYCLES = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pipe_mode_i,
   input  logic [1:0]        cmd_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              oe_ni,
   input  logic              sleep_i,
   output logic [DATA_W-1:0] dq_o,
   output logic [DATA_W/BYTE_W-1:0] dq_en_o
);
   import sram_rdret_pkg::*;

   localparam int NB = DATA_W / BYTE_W;

   if (DATA_W % BYTE_W != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of BYTE_W");
   end
   if (WAKE_CYCLES < 1) begin : g_bad_wake
      $error("WAKE_CYCLES must be at least 1");
   end

   logic              blocked;
   logic              take_read;
   logic [NB-1:0]     a_vld, b_vld;
   logic [DATA_W-1:0] a_data, b_data;
   logic              gate;

   rdret_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sleep_i   (sleep_i),
      .blocked_o (blocked)
   );

   assign take_read = !blocked && (cmd_e'(cmd_i) == CMD_READ);

   rdret_stage #(.DW(DATA_W), .NB(NB)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  ({NB{take_read}}),
      .data_i (rd_data_i),
      .vld_o  (a_vld),
      .data_o (a_data)
   );

   rdret_stage #(.DW(DATA_W), .NB(NB)) u_oreg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (a_vld),
      .data_i (a_data),
      .vld_o  (b_vld),
      .data_o (b_data)
   );

   assign gate = !oe_ni && !sleep_i;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      rdret_lane #(.BW(BYTE_W)) u_lane (
         .pipe_i   (pipe_mode_i),
         .gate_i   (gate),
         .a_vld_i  (a_vld[i]),
         .a_data_i (a_data[i*BYTE_W +: BYTE_W]),
         .b_vld_i  (b_vld[i]),
         .b_data_i (b_data[i*BYTE_W +: BYTE_W]),
         .en_o     (dq_en_o[i]),
         .dq_o     (dq_o[i*BYTE_W +: BYTE_W])
      );
   end
endmodule

// File: rtl/sram_rdret_chk.sv
module sram_rdret_chk #(
   parameter int DATA_W      = 32,
   parameter int BYTE_W      = 8,
   parameter int WAKE_CYCLES = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              pipe_mode_i,
   input logic [1:0]        cmd_i,
   input logic [DATA_W-1:0] rd_data_i,
   input logic              oe_ni,
   input logic              sleep_i,
   input logic [DATA_W-1:0] dq_o,
   input logic [DATA_W/BYTE_W-1:0] dq_en_o
);
   localparam int NB = DATA_W / BYTE_W;
   localparam int CW = $clog2(WAKE_CYCLES + 1);

   logic [CW-1:0] since_sleep;
   logic [1:0]    age;
   logic          ck_blk;
   logic          rd_ok;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         since_sleep <= CW'(WAKE_CYCLES);
         age         <= '0;
      end else begin
         if (sleep_i)                                since_sleep <= '0;
         else if (since_sleep != CW'(WAKE_CYCLES))  since_sleep <= since_sleep + 1'b1;
         if (age != 2'd3) age <= age + 1'b1;
      end
   end

   assign ck_blk = sleep_i || (since_sleep != CW'(WAKE_CYCLES));
   assign rd_ok  = (cmd_i == 2'b01) && !ck_blk;

   p_all_or_none_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dq_en_o == '0 || dq_en_o == {NB{1'b1}}) && (dq_en_o != '0 || dq_o == '0));

   p_oe_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_ni |-> dq_en_o == '0);

   p_sleep_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_i |-> dq_en_o == '0);

   p_write_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == 2'b10) |=> dq_en_o == '0);

   p_desel_scd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == 2'b00 || cmd_i == 2'b11) |=> dq_en_o == '0);

   p_blocked_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ck_blk && !pipe_mode_i) |=> (pipe_mode_i || dq_en_o == '0));

   p_flow_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ok && !pipe_mode_i) |=>
         (pipe_mode_i || oe_ni || sleep_i ||
          (dq_en_o == {NB{1'b1}} && dq_o == $past(rd_data_i))));

   p_pipe_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age == 2'd3 && pipe_mode_i && rd_ok && $past(rd_ok)) |=>
         (!pipe_mode_i || oe_ni || sleep_i ||
          (dq_en_o == {NB{1'b1}} && dq_o == $past(rd_data_i, 2))));
endmodule

bind sram_rdret sram_rdret_chk #(
   .DATA_W(DATA_W), .BYTE_W(BYTE_W), .WAKE_CYCLES(WAKE_CYCLES)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .pipe_mode_i(pipe_mode_i), .cmd_i(cmd_i),
   .rd_data_i(rd_data_i), .oe_ni(oe_ni), .sleep_i(sleep_i),
   .dq_o(dq_o), .dq_en_o(dq_en_o)
);

// File: tb/sram_rdret_test.sv
module sram_rdret_test;
   localparam int WAKE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode = 1'b0;
   logic [1:0]  cmd = 2'b00;
   logic [31:0] rdat = '0;
   logic        oe_n = 1'b0;
   logic        slp = 1'b0;
   logic [31:0] dq;
   logic [3:0]  en;

   int checks = 0;
   int failures = 0;

   // bench model state
   logic        ma_rd, mb_rd;
   logic [31:0] ma_d, mb_d;
   int          mwake;

   always #10 clk = ~clk;

   sram_rdret #(.WAKE_CYCLES(WAKE)) uut (
      .clk_i(clk), .rst_ni(rst_n), .pipe_mode_i(mode), .cmd_i(cmd),
      .rd_data_i(rdat), .oe_ni(oe_n), .sleep_i(slp), .dq_o(dq), .dq_en_o(en)
   );

   function automatic logic [3:0] exp_en();
      logic v;
      v = mode ? (mb_rd && ma_rd) : ma_rd;
      return (v && !oe_n && !slp) ? 4'hF : 4'h0;
   endfunction

   function automatic logic [31:0] exp_dq();
      if (exp_en() == 4'h0) return '0;
      return mode ? mb_d : ma_d;
   endfunction

   task automatic check(input string tag);
      checks++;
      if (en !== exp_en() || dq !== exp_dq()) begin
         failures++;
         $display("FAIL %s: en=%h dq=%h expected en=%h dq=%h",
                  tag, en, dq, exp_en(), exp_dq());
      end
   endtask

   task automatic model_reset();
      ma_rd = 0; mb_rd = 0; ma_d = '0; mb_d = '0; mwake = 0;
   endtask

   // drive at negedge, update model at posedge, check after edge
   task automatic step(input logic [1:0] c, input logic [31:0] d,
                       input logic o, input logic s, input string tag);
      logic blk;
      @(negedge clk);
      cmd = c; rdat = d; oe_n = o; slp = s;
      @(posedge clk);
      blk = slp || (mwake != 0);
      if (slp) mwake = WAKE; else if (mwake != 0) mwake--;
      mb_rd = ma_rd; mb_d = ma_d;
      ma_rd = !blk && (c == 2'b01);
      ma_d = d;
      #5;
      check(tag);
   endtask

   task automatic do_reset(input logic m);
      @(negedge clk);
      rst_n = 0; mode = m; cmd = 2'b00; oe_n = 0; slp = 0;
      model_reset();
      #1;
      check("R1");
      @(negedge clk);
      rst_n = 1;
      #1;
      check("R1");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      model_reset();
      // R1 reset
      do_reset(1'b0);
      // R2 flow-through single read
      step(2'b01, 32'hA1B2C3D4, 0, 0, "R2");
      step(2'b00, 32'h0, 0, 0, "R5");
      // R4 flow-through burst
      for (int i = 0; i < 4; i++) step(2'b01, 32'h1000 + i, 0, 0, "R4");
      // R6 write after read
      step(2'b10, 32'hDEAD0000, 0, 0, "R6");
      // R7 oe gate on a captured read, then async change mid-cycle
      step(2'b01, 32'h77, 1, 0, "R7");
      @(negedge clk); oe_n = 0; #1; check("R7");
      oe_n = 1; #1; check("R7");
      oe_n = 0;

      // pipelined
      do_reset(1'b1);
      step(2'b01, 32'h11111111, 0, 0, "R3");
      step(2'b01, 32'h22222222, 0, 0, "R3");
      step(2'b01, 32'h33333333, 0, 0, "R4");
      step(2'b00, 32'h0, 0, 0, "R5");
      step(2'b01, 32'h44444444, 0, 0, "R3");
      step(2'b10, 32'h0, 0, 0, "R6");
      // R9 sleep and R10 recovery
      step(2'b01, 32'h55, 0, 0, "R3");
      step(2'b01, 32'h66, 0, 1, "R9");
      step(2'b01, 32'h67, 0, 1, "R9");
      for (int i = 0; i < WAKE + 3; i++) step(2'b01, 32'h900 + i, 0, 0, "R10");

      // random phases in both modes
      for (int m = 0; m < 2; m++) begin
         do_reset(m[0]);
         for (int i = 0; i < 3000; i++) begin
            logic [1:0] c;
            c = $urandom_range(9) < 6 ? 2'b01 : 2'($urandom_range(3));
            step(c, $urandom(), ($urandom_range(9) == 0),
                 ($urandom_range(39) == 0), "R8");
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule